// File: doc/BRIEF.md
# Supply Fault Reset Sequencer

This block converts two digital undervoltage flags, one for the main supply and one for a secondary rail, into system reset signals. Whenever the main supply flag reports low, reset is raised in the same cycle. Reset is released only after the supply has stayed good for a programmable number of millisecond ticks, chosen by a 2-bit code. The same hold applies after the block's own reset, so a system coming out of power-up is held for the selected time. The secondary flag is passed straight out as a fail signal with no delay, so it can interrupt a processor early or be combined with reset on the board.

Next to the reset logic sits a fault status byte with three sticky cause bits: main supply, secondary supply and watchdog. Software arms a bit by writing 1 to it. The matching fault event then clears the bit to 0, and it stays 0 until software writes it again. After a reset, software reads the byte to find out what went wrong. All delays count an external tick input, so the same counter works with a real 1 ms tick or with a faster one.

Top module: `supply_reset_seq`

## Requirements
- R1: When `pri_low` is 1, `rst_hi_o` is 1 in the same cycle, and it stays 1 for as long as `pri_low` stays 1.
- R2: After `pri_low` returns to 0, `rst_hi_o` drops after exactly N cycles in which `ms_tick` is 1, with N given by `dly_code`: 2'b00 gives 50, 2'b01 gives 200, 2'b10 gives 400 and 2'b11 gives 800 (default parameters).
- R3: While `rst_n` is 0, `rst_hi_o` is 1. After `rst_n` goes high with the supply good, reset is held for the N ticks of the current code (200 for code 2'b01).
- R4: A cycle with `pri_low` = 1 during the release countdown restarts the count from zero, so a full N ticks are needed after the last low cycle.
- R5: The countdown advances only in cycles where `ms_tick` is 1. With `ms_tick` held at 0, reset never releases.
- R6: `sec_fail_o` equals `sec_low` in the same cycle, whatever the reset state.
- R7: `rst_lo_n_o` is always the inverse of `rst_hi_o`.
- R8: The fault byte is 8'h00 after reset. Bits 5, 3, 2, 1 and 0 always read 0, even when a write sets them to 1.
- R9: A cycle with `fault_wr_en` = 1 loads bits 7, 6 and 4 of the fault byte from the same bits of `fault_wr_data`. The new value is visible from the next cycle on.
- R10: A cycle with `pri_low` = 1 clears bit 7, `sec_low` = 1 clears bit 6, and `wdog_expire` = 1 clears bit 4. Each cleared bit stays 0 until a write sets it again.
- R11: When a write and a fault event fall in the same cycle, the fault wins and the affected bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the power-up hold |
| pri_low | input | 1 | Main supply below threshold |
| sec_low | input | 1 | Secondary supply below threshold |
| wdog_expire | input | 1 | One-cycle pulse when the watchdog times out |
| ms_tick | input | 1 | Time base; one pulse per delay unit |
| dly_code | input | 2 | Release delay select |
| fault_wr_en | input | 1 | Write strobe for the fault byte |
| fault_wr_data | input | 8 | Data written to the fault byte |
| rst_hi_o | output | 1 | System reset, active high |
| rst_lo_n_o | output | 1 | System reset, active low |
| sec_fail_o | output | 1 | Secondary supply fail, no delay |
| fault_byte_o | output | 8 | Fault status byte |

## Verification
The release counter is hidden state, and an error in it shows only as a reset that drops too early or too late. The bench therefore counts the ticks between the last low-supply cycle and the falling edge of `rst_hi_o` for every delay code. It also does this with a mid-countdown dip and with gaps in the tick, so an off-by-one or a missed restart shows up at the first release. A wrong sticky bit in the fault byte becomes visible one cycle after the write or event that should have set it. The bench reads the byte at that point and again later, to confirm that the bit holds.

// File: rtl/srs_pkg.sv
package srs_pkg;
   // bit positions of the three cause flags inside the fault byte
   localparam int unsigned FB_NUM = 3;
   localparam int unsigned FB_POS [FB_NUM] = '{7, 6, 4};
   // index of each cause inside the event vector
   localparam int unsigned EV_PRI = 0;
   localparam int unsigned EV_SEC = 1;
   localparam int unsigned EV_WDG = 2;
endpackage

// File: rtl/srs_release_timer.sv
module srs_release_timer #(
   parameter int unsigned D0_TICKS = 50,
   parameter int unsigned D1_TICKS = 200,
   parameter int unsigned D2_TICKS = 400,
   parameter int unsigned D3_TICKS = 800
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pri_low,
   input  logic       tick,
   input  logic [1:0] code,
   output logic       hold_o
);
   localparam int unsigned CNT_W = $clog2(D3_TICKS + 1);

   generate
      if (!(D0_TICKS > 0 && D0_TICKS <= D1_TICKS && D1_TICKS <= D2_TICKS
            && D2_TICKS <= D3_TICKS)) begin : g_bad_cfg
         $error("srs_release_timer: delay ticks must be nonzero and ascending");
      end
   endgenerate

   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt_q;
   logic             hold_q;

   always_comb begin
      unique case (code)
         2'b00:   lim = CNT_W'(D0_TICKS);
         2'b01:   lim = CNT_W'(D1_TICKS);
         2'b10:   lim = CNT_W'(D2_TICKS);
         default: lim = CNT_W'(D3_TICKS);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= 1'b1;
      end else if (pri_low) begin
         cnt_q  <= '0;
         hold_q <= 1'b1;
      end else if (hold_q && tick) begin
         if (cnt_q == lim - CNT_W'(1)) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign hold_o = hold_q;

   // R1
   low_sets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pri_low |=> hold_o);

   // R5
   release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> ($past(tick) && !$past(pri_low)));

   // R2
   count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> (cnt_q < lim || $changed(code)));
endmodule

// File: rtl/srs_fault_reg.sv
module srs_fault_reg
   import srs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic [FB_NUM-1:0] ev,
   output logic [7:0]        byte_o
);
   logic [FB_NUM-1:0] q;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^{wr_data[5], wr_data[3:0]};

   generate
      for (genvar i = 0; i < FB_NUM; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (ev[i])  q[i] <= 1'b0;
            else if (wr_en)  q[i] <= wr_data[FB_POS[i]];
         end

         // R10
         event_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> !byte_o[FB_POS[i]]);

         // R10
         sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !byte_o[FB_POS[i]]) |=> !byte_o[FB_POS[i]]);
      end
   endgenerate

   always_comb begin
      byte_o = 8'h00;
      for (int i = 0; i < FB_NUM; i++) byte_o[FB_POS[i]] = q[i];
   end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
   import srs_pkg::*;
#(
   parameter int unsigned D0_TICKS = 50,
   parameter int unsigned D1_TICKS = 200,
   parameter int unsigned D2_TICKS = 400,
   parameter int unsigned D3_TICKS = 800
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pri_low,
   input  logic       sec_low,
   input  logic       wdog_expire,
   input  logic       ms_tick,
   input  logic [1:0] dly_code,
   input  logic       fault_wr_en,
   input  logic [7:0] fault_wr_data,
   output logic       rst_hi_o,
   output logic       rst_lo_n_o,
   output logic       sec_fail_o,
   output logic [7:0] fault_byte_o
);
   logic              hold;
   logic [FB_NUM-1:0] ev;

   srs_release_timer #(
      .D0_TICKS(D0_TICKS), .D1_TICKS(D1_TICKS),
      .D2_TICKS(D2_TICKS), .D3_TICKS(D3_TICKS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .pri_low(pri_low),
      .tick   (ms_tick),
      .code   (dly_code),
      .hold_o (hold)
   );

   always_comb begin
      ev         = '0;
      ev[EV_PRI] = pri_low;
      ev[EV_SEC] = sec_low;
      ev[EV_WDG] = wdog_expire;
   end

   srs_fault_reg u_fault (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (fault_wr_en),
      .wr_data(fault_wr_data),
      .ev     (ev),
      .byte_o (fault_byte_o)
   );

   assign rst_hi_o   = hold | pri_low;
   assign rst_lo_n_o = ~rst_hi_o;
   assign sec_fail_o = sec_low;

   // R9
   write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_wr_en && !pri_low && fault_wr_data[7]) |=> fault_byte_o[7]);

   // R11
   fault_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_wr_en && wdog_expire) |=> !fault_byte_o[4]);
endmodule

// File: tb/supply_reset_seq_bench.sv
`timescale 1ns/1ps
module supply_reset_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pri_low = 1'b0, sec_low = 1'b0, wdog_expire = 1'b0, ms_tick = 1'b1;
   logic [1:0] dly_code = 2'b01;
   logic       fault_wr_en = 1'b0;
   logic [7:0] fault_wr_data = 8'h00;
   logic       rst_hi_o, rst_lo_n_o, sec_fail_o;
   logic [7:0] fault_byte_o;

   int tests = 0, fails = 0;
   int exp_q[$];
   int run = 0;
   logic prev_hi = 1'b1;
   int comp_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   supply_reset_seq u_supply_reset_seq (
      .clk(clk), .rst_n(rst_n), .pri_low(pri_low), .sec_low(sec_low),
      .wdog_expire(wdog_expire), .ms_tick(ms_tick), .dly_code(dly_code),
      .fault_wr_en(fault_wr_en), .fault_wr_data(fault_wr_data),
      .rst_hi_o(rst_hi_o), .rst_lo_n_o(rst_lo_n_o), .sec_fail_o(sec_fail_o),
      .fault_byte_o(fault_byte_o)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: ticks seen while held after the last low cycle, compared at release
   always @(negedge clk) begin
      if (rst_lo_n_o !== ~rst_hi_o) comp_bad++;
      if (rst_n) begin
         if (pri_low) run = 0;
         else if (rst_hi_o && ms_tick) run++;
         if (prev_hi && !rst_hi_o) begin
            if (exp_q.size() == 0) check("R2 unexpected release", run, -1);
            else check("R2/R3/R4 release ticks", run, exp_q.pop_front());
            run = 0;
         end
      end
      prev_hi = rst_hi_o;
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic pulse_low(input logic [1:0] code, input int exp_n);
      dly_code = code;
      exp_q.push_back(exp_n);
      step(); pri_low = 1'b1;
      step(); pri_low = 1'b0;
   endtask

   task automatic wait_release();
      while (exp_q.size() != 0) step();
   endtask

   task automatic wr(input logic [7:0] d);
      step(); fault_wr_en = 1'b1; fault_wr_data = d;
      step(); fault_wr_en = 1'b0;
   endtask

   task automatic chk_fault(input string req, input logic [7:0] exp);
      @(negedge clk);
      check(req, fault_byte_o, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R3 reset held during rst_n", rst_hi_o, 1);
      check("R7 low-active during rst_n", rst_lo_n_o, 0);
      check("R8 fault byte reset", fault_byte_o, 8'h00);
      exp_q.push_back(200);
      step(); rst_n = 1'b1;
      wait_release();

      // R6 immediate secondary fail
      step(); sec_low = 1'b1; #1;
      check("R6 sec fail follows high", sec_fail_o, 1);
      step(); sec_low = 1'b0; #1;
      check("R6 sec fail follows low", sec_fail_o, 0);

      // R9 / R8 arm and reserved bits
      wr(8'hFF);
      chk_fault("R9 R8 arm all", 8'hD0);

      // R1 immediate assert, R10 primary clears bit 7
      dly_code = 2'b00;
      exp_q.push_back(50);
      step(); pri_low = 1'b1; #1;
      check("R1 same-cycle assert", rst_hi_o, 1);
      step(); pri_low = 1'b0;
      chk_fault("R10 primary clears bit7", 8'h50);
      wait_release();
      chk_fault("R10 bit7 stays 0", 8'h50);

      // R2 other codes, R4 dip restarts
      pulse_low(2'b10, 400);
      repeat (100) step();
      step(); pri_low = 1'b1;
      step(); pri_low = 1'b0;
      wait_release();
      pulse_low(2'b11, 800);
      wait_release();

      // R5 no ticks: never releases; then sparse ticks
      pulse_low(2'b00, 50);
      ms_tick = 1'b0;
      repeat (300) step();
      check("R5 held without ticks", rst_hi_o, 1);
      while (exp_q.size() != 0) begin
         ms_tick = ~ms_tick;
         step();
      end
      ms_tick = 1'b1;

      // R11 write and fault in the same cycle
      step(); fault_wr_en = 1'b1; fault_wr_data = 8'hFF; wdog_expire = 1'b1; sec_low = 1'b1;
      step(); fault_wr_en = 1'b0; wdog_expire = 1'b0; sec_low = 1'b0;
      chk_fault("R11 fault wins over write", 8'h80);

      // R10 watchdog clears bit 4 only
      wr(8'hFF);
      chk_fault("R9 rearm", 8'hD0);
      step(); wdog_expire = 1'b1;
      step(); wdog_expire = 1'b0;
      chk_fault("R10 watchdog clears bit4", 8'hC0);
      repeat (5) step();
      chk_fault("R10 bit4 stays 0", 8'hC0);

      // R8 reserved bits written alone read 0
      wr(8'h2F);
      chk_fault("R8 reserved bits ignored", 8'h00);

      check("R7 complement every cycle", comp_bad, 0);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule